// File: doc/BRIEF.md
# Dual-Port Double-Data-Rate Burst SRAM

This block is a small synthesizable model of a memory with two independent ports. The read port drives its own output bus and the write port takes its own input bus, so the two never share a data wire and never need a bus turnaround. Both ports take their addresses from one shared address bus. Every access moves a pair of words. The words travel at double data rate, one word in each half of the external clock period.

The model runs on a single internal clock at twice the external burst clock rate. An input phase flag marks each internal edge as either the first half of the external period (the rising edge of the main clock) or the second half (the rising edge of the complementary clock). A read address is taken in the first half and a write address in the second half. Write words follow their address on the next two edges. Read words appear after a fixed latency of two external periods. A read that targets a write still in flight returns the newer words.

Neither data path has back-pressure, and there is no ready signal. Write words are accepted purely by their timing relative to the write address. `rd_valid` qualifies each read half-cycle and cannot be stalled. A consumer must take each word on the edge at which it is presented.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is asserted, and after it is released, `rd_valid` is 0 and `rd_data` is all zeros until a read is issued.
- R2: A read address is captured on an edge where `kph`=0 and `rd_sel_n`=0. A low `rd_sel_n` on an edge with `kph`=1 starts no read.
- R3: A write address is captured on an edge where `kph`=1 and `wr_sel_n`=0. Word 0 is taken from `wr_data` on the next edge (`kph`=0) and word 1 on the edge after that (`kph`=1). The array is updated at that second edge.
- R4: For a read captured at edge t, word 0 is presented on `rd_data` with `rd_valid`=1 after edge t+4, and word 1 after edge t+5. This is two external periods of latency.
- R5: A half-cycle that carries no read word holds `rd_valid`=0 and `rd_data`=0. A deselected read slot gives two such idle half-cycles.
- R6: A read captured in the external period after a write address returns that write's words, even though the array commit happens on the same edge as the read lookup.
- R7: A write whose address is captured in the same external period as a read, but after it (`kph`=1), is not seen by that read. The next read of that address sees it.
- R8: While `wr_sel_n` is high on `kph`=1 edges, `wr_data` and the address bus change no stored word.
- R9: `kph` alternates on every clock edge. Each address holds two words of `WORD_W` bits: word 0 is stored in bits [WORD_W-1:0] of a location and is always transferred first, and word 1 second.
- R10: A read and a write may be issued in every external period at the same time, with reads back to back and no lost or reordered bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the external burst clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| kph | input | 1 | Half-cycle flag: 0 marks the main rising edge, 1 marks the complementary rising edge |
| addr | input | $clog2(DEPTH) | Shared address bus: read address when `kph`=0, write address when `kph`=1 |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| wr_data | input | WORD_W | Write word input, one word per half-cycle |
| rd_data | output | WORD_W | Read word output, one word per half-cycle, zero when idle |
| rd_valid | output | 1 | High for each half-cycle that carries a read word |

## Verification
A corrupted write holding stage shows up as a wrong word on the very next read of that address. For a forwarded read this is four edges after the read address is taken. A wrong phase decode or latency pipeline makes `rd_valid` rise one or more edges away from t+4, which the per-edge comparison reports on that edge. A swapped word order shows on the first read burst whose two words differ. A missing forwarding path shows on the first read that immediately follows a write to the same address.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  // Which half of the external period an internal edge belongs to.
  typedef enum logic {
    PH_K  = 1'b0,  // main rising edge: read address, write word 0
    PH_KN = 1'b1   // complementary rising edge: write address, write word 1
  } half_e;
endpackage

// File: rtl/qdr_wr_path.sv
module qdr_wr_path
  import qdr_pkg::*;
#(
  parameter int AW     = 6,
  parameter int WORD_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kph,
  input  logic [AW-1:0]       addr,
  input  logic                wps_n,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                cm_en,
  output logic [AW-1:0]       cm_addr,
  output logic [2*WORD_W-1:0] cm_data
);
  localparam int PW = 2 * WORD_W;

  half_e             ph;
  logic              cap_vld;
  logic [AW-1:0]     cap_addr;
  logic              hold_vld;
  logic [AW-1:0]     hold_addr;
  logic [WORD_W-1:0] hold_w0;

  assign ph = half_e'(kph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld   <= 1'b0;
      cap_addr  <= '0;
      hold_vld  <= 1'b0;
      hold_addr <= '0;
      hold_w0   <= '0;
    end else if (ph == PH_KN) begin
      cap_vld  <= ~wps_n;
      cap_addr <= addr;
      hold_vld <= 1'b0;
    end else begin
      hold_vld  <= cap_vld;
      hold_addr <= cap_addr;
      hold_w0   <= wr_data;
      cap_vld   <= 1'b0;
    end
  end

  assign cm_en   = hold_vld && (ph == PH_KN);
  assign cm_addr = hold_addr;
  assign cm_data = {wr_data, hold_w0};

  // R3
  wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kph && !wps_n) |-> ##2 cm_en);

  // R9
  wr_pair_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_en |-> ($past(kph) == 1'b0)) else $error("commit not preceded by word 0 half");

  localparam int UNUSED_PW = PW;
endmodule

// File: rtl/qdr_mem_array.sv
module qdr_mem_array #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int PW    = 36
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] rdata
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qdr_rd_path.sv
module qdr_rd_path
  import qdr_pkg::*;
#(
  parameter int AW     = 6,
  parameter int WORD_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kph,
  input  logic [AW-1:0]       addr,
  input  logic                rps_n,
  output logic [AW-1:0]       arr_raddr,
  input  logic [2*WORD_W-1:0] arr_rdata,
  input  logic                fw_vld,
  input  logic [AW-1:0]       fw_addr,
  input  logic [2*WORD_W-1:0] fw_data,
  output logic [WORD_W-1:0]   rd_data,
  output logic                rd_valid
);
  localparam int PW = 2 * WORD_W;

  half_e             ph;
  logic              ra_vld;
  logic [AW-1:0]     ra_addr;
  logic              lk_vld;
  logic [PW-1:0]     lk_pair;
  logic              hd_vld;
  logic [PW-1:0]     hd_pair;
  logic              tl_vld;
  logic [WORD_W-1:0] tl_w1;
  logic [PW-1:0]     look;

  assign ph        = half_e'(kph);
  assign arr_raddr = ra_addr;
  // newest words win: a write committing on this same edge is forwarded
  assign look      = (fw_vld && fw_addr == ra_addr) ? fw_data : arr_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_vld   <= 1'b0;
      ra_addr  <= '0;
      lk_vld   <= 1'b0;
      lk_pair  <= '0;
      hd_vld   <= 1'b0;
      hd_pair  <= '0;
      tl_vld   <= 1'b0;
      tl_w1    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (ph == PH_K) begin
      ra_vld   <= ~rps_n;
      ra_addr  <= addr;
      hd_vld   <= lk_vld;
      hd_pair  <= lk_pair;
      tl_vld   <= hd_vld;
      tl_w1    <= hd_pair[PW-1:WORD_W];
      rd_valid <= hd_vld;
      rd_data  <= hd_vld ? hd_pair[WORD_W-1:0] : '0;
    end else begin
      ra_vld   <= 1'b0;
      lk_vld   <= ra_vld;
      lk_pair  <= look;
      rd_valid <= tl_vld;
      rd_data  <= tl_vld ? tl_w1 : '0;
    end
  end

  // edges since reset, for the latency check window
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= '0;
    else if (age != 3'd7)  age <= age + 3'd1;
  end

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  // R4
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd6 && kph) |-> (rd_valid == $past(!rps_n && !kph, 5)));

  // R9
  burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> !$past(kph));
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter  int DEPTH  = 64,
  parameter  int WORD_W = 18,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kph,
  input  logic [AW-1:0]     addr,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int PW = 2 * WORD_W;

  logic          cm_en;
  logic [AW-1:0] cm_addr;
  logic [PW-1:0] cm_data;
  logic [AW-1:0] arr_raddr;
  logic [PW-1:0] arr_rdata;

  qdr_wr_path #(.AW(AW), .WORD_W(WORD_W)) wr_i (
    .clk(clk), .rst_n(rst_n), .kph(kph), .addr(addr), .wps_n(wr_sel_n),
    .wr_data(wr_data), .cm_en(cm_en), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  qdr_mem_array #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) mem_i (
    .clk(clk), .we(cm_en), .waddr(cm_addr), .wdata(cm_data),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  qdr_rd_path #(.AW(AW), .WORD_W(WORD_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .kph(kph), .addr(addr), .rps_n(rd_sel_n),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .fw_vld(cm_en), .fw_addr(cm_addr), .fw_data(cm_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R9
  kph_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (kph != $past(kph)));
endmodule

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb_top;
  localparam int DEPTH = 64;
  localparam int W     = 18;
  localparam int AW    = 6;
  localparam int PW    = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          kph = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;
  logic          rd_valid;

  qdr_burst_sram #(.DEPTH(DEPTH), .WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .kph(kph), .addr(addr), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    n_chk = 0;
  int    n_err = 0;
  string req = "R1";
  bit    done = 1'b0;

  // ---------------- behavioural reference ----------------
  logic [PW-1:0] ref_mem [DEPTH];
  int            cyc;
  bit            r_pend, w_cap, w_hold;
  int            r_addr, w_addr, w_haddr;
  logic [W-1:0]  w_d0;
  bit            ev [8];
  logic [W-1:0]  ed [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; r_pend = 0; w_cap = 0; w_hold = 0;
      for (int i = 0; i < 8; i++) begin ev[i] = 0; ed[i] = '0; end
    end else begin
      cyc++;
      if (kph) begin
        // commit first, then resolve the read taken one half earlier
        if (w_hold) ref_mem[w_haddr] = {wr_data, w_d0};
        w_hold = 0;
        if (r_pend) begin
          ev[(cyc + 3) % 8] = 1; ed[(cyc + 3) % 8] = ref_mem[r_addr][W-1:0];
          ev[(cyc + 4) % 8] = 1; ed[(cyc + 4) % 8] = ref_mem[r_addr][PW-1:W];
        end
        r_pend = 0;
        w_cap  = !wr_sel_n;
        w_addr = int'(addr);
      end else begin
        w_hold  = w_cap; w_haddr = w_addr; w_d0 = wr_data; w_cap = 0;
        r_pend  = !rd_sel_n;
        r_addr  = int'(addr);
      end
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s edge %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cyc > 0 && !done) begin
      check({req, " valid"}, W'(rd_valid), W'(ev[cyc % 8]));
      check({req, " data"}, rd_data, ev[cyc % 8] ? ed[cyc % 8] : '0);
      ev[cyc % 8] = 0;
    end
  end

  // ---------------- stimulus ----------------
  bit            pend = 0;
  logic [PW-1:0] pd = '0;

  function automatic logic [PW-1:0] rnd_pair();
    return {$urandom, $urandom};
  endfunction

  // one external period: read slot in first half, write slot in second half;
  // write words of the previous period's write go out on these two halves
  task automatic kcyc(input bit rd, input int ra, input bit wr, input int wa, input logic [PW-1:0] wd);
    @(negedge clk);
    kph = 1'b0; addr = AW'(ra); rd_sel_n = !rd;
    wr_sel_n = 1'($urandom);              // ignored on this half
    wr_data  = pend ? pd[W-1:0] : W'($urandom);
    @(negedge clk);
    kph = 1'b1; addr = AW'(wa);
    rd_sel_n = 1'($urandom);              // ignored on this half (R2)
    wr_sel_n = !wr;
    wr_data  = pend ? pd[PW-1:W] : W'($urandom);
    pend = wr; pd = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) kcyc(0, 0, 0, 0, '0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1 valid in reset", W'(rd_valid), '0);
    check("R1 data in reset", rd_data, '0);
    @(negedge clk);
    rst_n = 1'b1; kph = 1'b1; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", W'(rd_valid), '0);
    check("R1 data after reset", rd_data, '0);
    kph = 1'b0;
    // kph now low; next kcyc drives kph low again, so spend one high half first
    @(negedge clk); kph = 1'b1;

    // R3: fill every location
    req = "R3";
    for (int a = 0; a < DEPTH; a++) kcyc(0, 0, 1, a, rnd_pair());
    idle(3);

    // R2 R4: read every location back to back
    req = "R2,R4";
    for (int a = 0; a < DEPTH; a++) kcyc(1, a, 0, 0, '0);
    idle(3);

    // R9: distinct word halves, word 0 first
    req = "R9";
    for (int i = 0; i < 8; i++) begin
      kcyc(0, 0, 1, i, {W'(18'h3F000 + i), W'(18'h00A00 + i)});
      kcyc(1, i, 0, 0, '0);
    end
    idle(3);

    // R6: read right after write to same address (forwarding)
    req = "R6";
    for (int i = 0; i < 20; i++) begin
      int a = int'($urandom % DEPTH);
      kcyc(0, 0, 1, a, rnd_pair());
      kcyc(1, a, 0, 0, '0);
    end
    idle(3);

    // R7: write after read in same period is not seen, next read sees it
    req = "R7";
    for (int i = 0; i < 12; i++) begin
      int a = int'($urandom % DEPTH);
      kcyc(1, a, 1, a, rnd_pair());
      kcyc(1, a, 0, 0, '0);
    end
    idle(3);

    // R8: write port deselected, bus noise, then read back
    req = "R8";
    for (int i = 0; i < 16; i++) kcyc(0, 0, 0, int'($urandom % DEPTH), rnd_pair());
    for (int a = 0; a < 16; a++) kcyc(1, a, 0, 0, '0);
    idle(3);

    // R5: gaps in the read stream give idle halves
    req = "R5";
    for (int i = 0; i < 30; i++) kcyc((i % 3) != 0, i, 0, 0, '0);
    idle(3);

    // R10: concurrent random traffic on a small address set
    req = "R10";
    for (int i = 0; i < 400; i++)
      kcyc(1'($urandom), int'($urandom % 8), 1'($urandom), int'($urandom % 8), rnd_pair());
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule